// File: doc/BRIEF.md
# Vector Condition-Field to Integer Bit Packer

This engine walks through up to eight elements of a condition-field test and turns each into one result bit. For every element it picks one 4-bit field of a 32-bit condition register. It compares each field bit with a mode bit, keeps only the terms a mask enables, and reduces the four terms to one bit with OR or AND. The result bits are then packed into 64-bit integer words, which leave through a single register-file write port.

The source can be a vector or a scalar. A vector source moves to the next condition field on each element, and a scalar source tests the same field every time. The destination can also be a vector or a scalar. A vector destination packs 1, 2, 4 or 8 results into each register and then moves to the next register. A 2-bit packing code on the source side chooses that density. A scalar destination collects every result into one register, one bit position per element.

The control is a three-state machine:
- `ST_IDLE` waits for `start_i` and latches the command. It goes to `ST_DONE` when the clamped length is zero, and to `ST_EVAL` otherwise.
- `ST_EVAL` handles one element per cycle. It stays in `ST_EVAL` until the last element, then goes to `ST_DONE`.
- `ST_DONE` raises `done_o` for one cycle and always returns to `ST_IDLE`.

Top module: `cr_pack_engine`

## Requirements
- R1: After reset, `wr_en_o`, `done_o` and `busy_o` are low, and they stay low until a start is accepted.
- R2: The field-bit order is as follows. Field f sits at `cr_i[31-4f : 28-4f]`, and field bit j (j = 0..3) is `cr_i[31-4f-j]`.
- R2: An element's result bit combines the terms t_j = `mask_i[j]` AND (`mode_i[j]` == field bit j). With `or_sel_i`=1 the result is the OR of the four t_j. With `or_sel_i`=0 it is their AND.
- R3: With `src_vec_i`=1, element i tests field (`src_fld_i`+i) mod 8. With `src_vec_i`=0, every element tests field `src_fld_i`.
- R4: With `dst_vec_i`=1 the packing factor k is set by `pack_code_i`: 00→1, 01→2, 10→4, 11→8. Element i goes to register (`dst_reg_i`+floor(i/k)) mod 32 at bit (i mod k). All other bits of each written word are zero.
- R5: In vector-destination mode, a word is written when the element at offset k−1 of its group is done. A partial final group is written after the last element. Each word is written exactly once, in ascending register order.
- R6: With `dst_vec_i`=0, exactly one word is written, to `dst_reg_i`. Its bit i holds element i, and bits at positions VL and above are zero, whatever an earlier command left behind.
- R7: Take the edge that accepts start as edge 0. A write for a group that closes at element i appears after edge i+1. `done_o` rises after edge VL and is high for exactly one cycle.
- R8: VL=0 raises `done_o` after edge 0 and produces no write.
- R9: A `vl_i` above 8 is treated as 8.
- R10: While `busy_o` is high (from edge 0 through the done cycle), `start_i` is ignored. All command inputs are latched at edge 0; `cr_i` is not latched and must be held stable while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a command (accepted only when idle) |
| vl_i | input | 4 | Element count, 0..8 (values above 8 are clamped) |
| mask_i | input | 4 | Term enables; bit j pairs with field bit j |
| mode_i | input | 4 | Compare values; bit j pairs with field bit j |
| or_sel_i | input | 1 | 1 = OR reduction, 0 = AND reduction |
| src_fld_i | input | 3 | Base condition field index |
| src_vec_i | input | 1 | Source advances one field per element |
| dst_reg_i | input | 5 | Base destination register index |
| dst_vec_i | input | 1 | Destination advances registers by packing factor |
| pack_code_i | input | 2 | Results per destination word: 1/2/4/8 |
| cr_i | input | 32 | Condition register contents |
| wr_en_o | output | 1 | Register-file write strobe |
| wr_addr_o | output | 5 | Register-file write index |
| wr_data_o | output | 64 | Register-file write word |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each result is due at a fixed cycle:
- Counting from the edge that accepts start, the write for a group closing at element i is due after edge i+1.
- The completion pulse is due after edge VL, which is edge 0 for an empty command.

The bench drives inputs and samples outputs only on falling edges, and numbers each falling edge from the start. It records the cycle number of every write and of the done pulse, and compares them with the cycle numbers the requirements predict. The address, data and count of the writes are compared separately. The done pulse is also checked to be low on the next falling edge.

// File: rtl/cr_pack_pkg.sv
package cr_pack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DONE = 2'd2
    } pack_state_e;

endpackage

// File: rtl/cr_field_select.sv
module cr_field_select #(
    parameter int NFIELDS = 8,
    parameter int FIELD_W = 4,
    localparam int SEL_W  = $clog2(NFIELDS),
    localparam int CR_W   = NFIELDS * FIELD_W
) (
    input  logic [CR_W-1:0]    cr_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [FIELD_W-1:0] bits_o   // bits_o[j] = field bit j (first bit is most significant)
);
    logic [FIELD_W-1:0] fields [NFIELDS];

    for (genvar f = 0; f < NFIELDS; f++) begin : g_field
        for (genvar j = 0; j < FIELD_W; j++) begin : g_bit
            assign fields[f][j] = cr_i[CR_W-1-f*FIELD_W-j];
        end
    end

    assign bits_o = fields[sel_i];
endmodule

// File: rtl/cr_term_reduce.sv
module cr_term_reduce #(
    parameter int FIELD_W = 4
) (
    input  logic [FIELD_W-1:0] bits_i,
    input  logic [FIELD_W-1:0] mask_i,
    input  logic [FIELD_W-1:0] mode_i,
    input  logic               or_sel_i,
    output logic               res_o
);
    logic [FIELD_W-1:0] terms;

    for (genvar j = 0; j < FIELD_W; j++) begin : g_term
        assign terms[j] = mask_i[j] & ~(mode_i[j] ^ bits_i[j]);
    end

    assign res_o = or_sel_i ? (|terms) : (&terms);
endmodule

// File: rtl/cr_pack_place.sv
module cr_pack_place #(
    parameter int VL_W   = 4,
    parameter int OFF_W  = 3,
    parameter int REG_AW = 5
) (
    input  logic [VL_W-1:0]   idx_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [1:0]        code_i,
    input  logic              dvec_i,
    input  logic [REG_AW-1:0] base_i,
    output logic [OFF_W-1:0]  off_o,
    output logic              close_o,
    output logic              last_o,
    output logic [REG_AW-1:0] addr_o
);
    logic [VL_W-1:0] grp_mask;
    logic [VL_W-1:0] in_grp;
    logic [VL_W-1:0] grp_num;

    always_comb begin
        grp_mask = VL_W'((4'b1 << code_i) - 4'b1);
        in_grp   = idx_i & grp_mask;
        grp_num  = idx_i >> code_i;
        last_o   = (idx_i == vl_i - VL_W'(1));
        off_o    = dvec_i ? OFF_W'(in_grp) : OFF_W'(idx_i);
        close_o  = last_o | (dvec_i & (in_grp == grp_mask));
        addr_o   = dvec_i ? base_i + REG_AW'(grp_num) : base_i;
    end
endmodule

// File: rtl/cr_pack_engine.sv
module cr_pack_engine
    import cr_pack_pkg::*;
#(
    parameter int NFIELDS = 8,
    parameter int FIELD_W = 4,
    parameter int XLEN    = 64,
    parameter int REG_AW  = 5,
    parameter int MAX_VL  = 8,
    localparam int SEL_W  = $clog2(NFIELDS),
    localparam int CR_W   = NFIELDS * FIELD_W,
    localparam int VL_W   = $clog2(MAX_VL) + 1,
    localparam int OFF_W  = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [FIELD_W-1:0] mask_i,
    input  logic [FIELD_W-1:0] mode_i,
    input  logic              or_sel_i,
    input  logic [SEL_W-1:0]  src_fld_i,
    input  logic              src_vec_i,
    input  logic [REG_AW-1:0] dst_reg_i,
    input  logic              dst_vec_i,
    input  logic [1:0]        pack_code_i,
    input  logic [CR_W-1:0]   cr_i,
    output logic              wr_en_o,
    output logic [REG_AW-1:0] wr_addr_o,
    output logic [XLEN-1:0]   wr_data_o,
    output logic              busy_o,
    output logic              done_o
);
    pack_state_e state_q, state_d;

    logic [VL_W-1:0]    idx_q;
    logic [VL_W-1:0]    vl_q;
    logic [FIELD_W-1:0] mask_q;
    logic [FIELD_W-1:0] mode_q;
    logic               or_q;
    logic [SEL_W-1:0]   src_q;
    logic               svec_q;
    logic [REG_AW-1:0]  dst_q;
    logic               dvec_q;
    logic [1:0]         code_q;
    logic [XLEN-1:0]    acc_q;

    logic [VL_W-1:0]    vl_clamp;
    logic               accept;
    logic [SEL_W-1:0]   fld_sel;
    logic [FIELD_W-1:0] fld_bits;
    logic               res_bit;
    logic [OFF_W-1:0]   bit_off;
    logic               grp_close;
    logic               elem_last;
    logic [REG_AW-1:0]  grp_addr;
    logic [XLEN-1:0]    acc_next;

    assign vl_clamp = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;
    assign accept   = (state_q == ST_IDLE) && start_i;
    assign fld_sel  = svec_q ? src_q + SEL_W'(idx_q) : src_q;

    cr_field_select #(
        .NFIELDS (NFIELDS),
        .FIELD_W (FIELD_W)
    ) u_sel (
        .cr_i   (cr_i),
        .sel_i  (fld_sel),
        .bits_o (fld_bits)
    );

    cr_term_reduce #(
        .FIELD_W (FIELD_W)
    ) u_reduce (
        .bits_i   (fld_bits),
        .mask_i   (mask_q),
        .mode_i   (mode_q),
        .or_sel_i (or_q),
        .res_o    (res_bit)
    );

    cr_pack_place #(
        .VL_W   (VL_W),
        .OFF_W  (OFF_W),
        .REG_AW (REG_AW)
    ) u_place (
        .idx_i   (idx_q),
        .vl_i    (vl_q),
        .code_i  (code_q),
        .dvec_i  (dvec_q),
        .base_i  (dst_q),
        .off_o   (bit_off),
        .close_o (grp_close),
        .last_o  (elem_last),
        .addr_o  (grp_addr)
    );

    assign acc_next = acc_q | (XLEN'(res_bit) << bit_off);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = (vl_clamp == '0) ? ST_DONE : ST_EVAL;
            ST_EVAL: if (elem_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // command latch, accumulator and write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            vl_q      <= '0;
            mask_q    <= '0;
            mode_q    <= '0;
            or_q      <= 1'b0;
            src_q     <= '0;
            svec_q    <= 1'b0;
            dst_q     <= '0;
            dvec_q    <= 1'b0;
            code_q    <= '0;
            acc_q     <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (accept) begin
                idx_q  <= '0;
                vl_q   <= vl_clamp;
                mask_q <= mask_i;
                mode_q <= mode_i;
                or_q   <= or_sel_i;
                src_q  <= src_fld_i;
                svec_q <= src_vec_i;
                dst_q  <= dst_reg_i;
                dvec_q <= dst_vec_i;
                code_q <= pack_code_i;
                acc_q  <= '0;
            end else if (state_q == ST_EVAL) begin
                idx_q <= idx_q + VL_W'(1);
                if (grp_close) begin
                    wr_en_o   <= 1'b1;
                    wr_addr_o <= grp_addr;
                    wr_data_o <= acc_next;
                    acc_q     <= '0;
                end else begin
                    acc_q <= acc_next;
                end
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/cr_pack_engine_chk.sv
module cr_pack_engine_chk #(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            wr_en_o,
    input logic [XLEN-1:0] wr_data_o,
    input logic            busy_o,
    input logic            done_o
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!wr_en_o && !done_o));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_data_o[XLEN-1:MAX_VL] == '0));

    assert_write_in_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_start_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind cr_pack_engine cr_pack_engine_chk #(
    .XLEN   (XLEN),
    .MAX_VL (MAX_VL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/cr_pack_engine_bench.sv
module cr_pack_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  vl_i = '0;
    logic [3:0]  mask_i = '0;
    logic [3:0]  mode_i = '0;
    logic        or_sel_i = 1'b0;
    logic [2:0]  src_fld_i = '0;
    logic        src_vec_i = 1'b0;
    logic [4:0]  dst_reg_i = '0;
    logic        dst_vec_i = 1'b0;
    logic [1:0]  pack_code_i = '0;
    logic [31:0] cr_i = '0;
    logic        wr_en_o;
    logic [4:0]  wr_addr_o;
    logic [63:0] wr_data_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cr_pack_engine u_cr_pack_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .mask_i(mask_i), .mode_i(mode_i), .or_sel_i(or_sel_i),
        .src_fld_i(src_fld_i), .src_vec_i(src_vec_i), .dst_reg_i(dst_reg_i),
        .dst_vec_i(dst_vec_i), .pack_code_i(pack_code_i), .cr_i(cr_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2: term j uses mask[j], mode[j] and cr[31-4f-j]
    function automatic logic model_bit(input logic [31:0] cr, input int f,
                                       input logic [3:0] mk, input logic [3:0] md,
                                       input logic m);
        logic o_r = 1'b0;
        logic a_r = 1'b1;
        for (int j = 0; j < 4; j++) begin
            logic t;
            t = mk[j] & (md[j] == cr[31-4*f-j]);
            o_r |= t;
            a_r &= t;
        end
        return m ? o_r : a_r;
    endfunction

    task automatic run_case(input string tag, input logic [31:0] cr, input int vl,
                            input logic [3:0] mk, input logic [3:0] md, input logic m,
                            input int src, input logic svec, input int dst,
                            input logic dvec, input int code, input logic poke);
        logic [4:0]  e_addr [8];
        logic [63:0] e_data [8];
        int          e_cyc  [8];
        logic [4:0]  a_addr [8];
        logic [63:0] a_data [8];
        int          a_cyc  [8];
        int e_n = 0;
        int a_n = 0;
        int n;
        int k;
        int done_cyc = -1;
        logic [63:0] acc = '0;

        n = (vl > 8) ? 8 : vl;
        k = 1 << code;
        for (int i = 0; i < n; i++) begin
            int f;
            int off;
            logic cl;
            f   = svec ? ((src + i) % 8) : src;
            off = dvec ? (i % k) : i;
            acc[off] = model_bit(cr, f, mk, md, m);
            cl = (i == n - 1) || (dvec && (i % k == k - 1));
            if (cl) begin
                e_addr[e_n] = dvec ? 5'((dst + i / k) % 32) : 5'(dst);
                e_data[e_n] = acc;
                e_cyc[e_n]  = i + 2;
                e_n++;
                acc = '0;
            end
        end

        @(negedge clk);
        cr_i = cr; vl_i = 4'(vl); mask_i = mk; mode_i = md; or_sel_i = m;
        src_fld_i = 3'(src); src_vec_i = svec; dst_reg_i = 5'(dst);
        dst_vec_i = dvec; pack_code_i = 2'(code); start_i = 1'b1;
        for (int c = 1; c <= 30; c++) begin
            @(negedge clk);
            if (c == 1) start_i = 1'b0;
            if (poke && c == 2) begin
                start_i = 1'b1; dst_reg_i = 5'd9; vl_i = 4'd1;
                mask_i = ~mk; mode_i = ~md; dst_vec_i = ~dvec;
            end
            if (wr_en_o && a_n < 8) begin
                a_addr[a_n] = wr_addr_o;
                a_data[a_n] = wr_data_o;
                a_cyc[a_n]  = c;
                a_n++;
            end
            if (done_o) begin
                done_cyc = c;
                start_i = 1'b0;
                @(negedge clk);
                check({tag, " R7 done one cycle"}, 64'(done_o), 64'd0);
                check({tag, " R1 idle after done"}, 64'(busy_o), 64'd0);
                break;
            end
        end
        start_i = 1'b0;
        check({tag, " R7 done cycle"}, 64'(done_cyc), 64'(n + 1));
        check({tag, " R5 write count"}, 64'(a_n), 64'(e_n));
        for (int w = 0; w < e_n && w < a_n; w++) begin
            check({tag, " R4 write addr"}, 64'(a_addr[w]), 64'(e_addr[w]));
            check({tag, " R3 write data"}, a_data[w], e_data[w]);
            check({tag, " R7 write cycle"}, 64'(a_cyc[w]), 64'(e_cyc[w]));
        end
    endtask

    task automatic test_reset();
        check("R1 wr_en after reset", 64'(wr_en_o), 64'd0);
        check("R1 done after reset", 64'(done_o), 64'd0);
        check("R1 busy after reset", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // R6 scalar dest, R3 scalar src, R2 OR reduction
        run_case("R6 scalar OR",   32'hA5C3_0F96, 5, 4'b0110, 4'b0100, 1'b1, 2, 1'b0, 7,  1'b0, 0, 1'b0);
        // R3 vector src, R4 k=1, R2 AND reduction
        run_case("R4 k1 AND",      32'h1234_F0E7, 3, 4'b1111, 4'b1000, 1'b0, 0, 1'b1, 4,  1'b1, 0, 1'b0);
        // R5 k=2 with partial tail group
        run_case("R5 k2 tail",     32'h9C3A_5E71, 5, 4'b1010, 4'b0010, 1'b1, 1, 1'b1, 10, 1'b1, 1, 1'b0);
        // R4 k=4 full groups
        run_case("R4 k4",          32'h6B2D_84F1, 8, 4'b0011, 4'b0001, 1'b1, 0, 1'b1, 2,  1'b1, 2, 1'b0);
        // R3 field wrap, R4 k=8
        run_case("R3 wrap k8",     32'hF00F_3CC3, 7, 4'b1001, 4'b1000, 1'b1, 6, 1'b1, 20, 1'b1, 3, 1'b0);
        // R4 register index wrap
        run_case("R4 reg wrap",    32'h8421_7BDE, 4, 4'b0100, 4'b0000, 1'b1, 5, 1'b1, 30, 1'b1, 0, 1'b0);
        // R8 empty command
        run_case("R8 vl0",         32'hFFFF_FFFF, 0, 4'b1111, 4'b1111, 1'b1, 0, 1'b1, 3,  1'b1, 0, 1'b0);
        // R9 clamp
        run_case("R9 clamp",       32'h5A5A_C3C3, 12, 4'b0001, 4'b0001, 1'b1, 3, 1'b1, 1, 1'b0, 0, 1'b0);
        // R10 start during busy ignored
        run_case("R10 ignore",     32'h0F1E_2D3C, 6, 4'b1100, 4'b0100, 1'b1, 4, 1'b1, 12, 1'b1, 1, 1'b1);
        // R6 scalar after a run: short run must clear stale bits
        run_case("R6 short",       32'hFFFF_FFFF, 2, 4'b1111, 4'b1111, 1'b0, 0, 1'b1, 7,  1'b0, 0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule